// File: doc/BRIEF.md
# Chip-Select Strobe Timing Generator

This block drives the four control strobes of one asynchronous external memory access: chip select, address latch, output enable and write enable. All four are active low. Each strobe is asserted over a window of ticks. A tick counter starts at zero when the access begins, and each window's start and end ticks come from static timing inputs. A read also gives a one-clock capture pulse at the access tick. Every access gives a one-clock completion pulse on its final tick.

Each access is followed by a programmable idle spell for bus turnaround. An access may also be preceded by an extra hold. The hold applies when the new access targets the same chip-select number as the previous one, or a different one, depending on two independent enables. Any strobe can be moved half a clock later by retiming it on the falling edge. A request that arrives while the block is busy is kept until the block is idle, and is then started.

Top module: `csx_cycle_gen`

## Requirements
- R1: After reset all four strobes are high, and capture and completion are low.
- R2: On a read, chip select is active from tick cs_on through the access tick. Output enable is active from tick oe_on through the access tick. Both go inactive one tick after the access tick. Capture pulses for exactly the clock whose tick equals the access value.
- R3: On a write, chip select is active for ticks cs_on up to but not including cs_wr_off. Write enable is active for ticks we_on up to but not including we_off. Output enable and capture stay inactive.
- R4: The address latch strobe is active for ticks adv_on up to but not including the read-off value on reads, or the write-off value on writes.
- R5: With mux_mode_i high, the address latch strobe is active for at least the tick adv_on, even when the programmed off value is not greater than adv_on. With mux_mode_i low, a window whose off value is not greater than its on value never asserts.
- R6: Ticks advance by one per clock. The cycle ends on the clock whose tick equals rd_len_i for reads or wr_len_i for writes, and the completion pulse is high for that clock only.
- R7: half_dly_i bit 0 selects chip select, bit 1 the address latch, bit 2 output enable and bit 3 write enable. When a strobe's bit is set, that strobe's edges are moved half a clock later, so just after a rising edge it still shows the window value of the previous tick.
- R8: After the completion clock, turn_i clocks pass with every strobe inactive before the block is idle again.
- R9: When c2c_same_en_i is high and c2c_i is nonzero, an access to the same chip-select number as the previous access waits c2c_i clocks, all strobes inactive, before tick 0. When c2c_same_en_i is low, it does not wait.
- R10: When c2c_diff_en_i is high and c2c_i is nonzero, an access to a different chip-select number waits c2c_i clocks before tick 0. When c2c_diff_en_i is low, it does not wait. The first access after reset never waits.
- R11: A request pulse that arrives during an access, hold or turnaround is kept with its direction and chip-select number. It is started after the block returns to idle, one idle clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock request pulse |
| req_write_i | input | 1 | Direction of the request, 1 = write |
| req_cs_i | input | CS_W | Chip-select number of the request |
| mux_mode_i | input | 1 | Address/data multiplexed mode |
| half_dly_i | input | 4 | Half-clock delay selects (0 cs, 1 adv, 2 oe, 3 we) |
| cs_on_i | input | TICK_W | Chip-select assert tick |
| cs_wr_off_i | input | TICK_W | Chip-select deassert tick on writes |
| adv_on_i | input | TICK_W | Address latch assert tick |
| adv_rd_off_i | input | TICK_W | Address latch deassert tick on reads |
| adv_wr_off_i | input | TICK_W | Address latch deassert tick on writes |
| oe_on_i | input | TICK_W | Output enable assert tick |
| we_on_i | input | TICK_W | Write enable assert tick |
| we_off_i | input | TICK_W | Write enable deassert tick |
| access_i | input | TICK_W | Read data sampling tick |
| rd_len_i | input | TICK_W | Final tick of a read |
| wr_len_i | input | TICK_W | Final tick of a write |
| turn_i | input | GAP_W | Turnaround clocks after each access |
| c2c_i | input | GAP_W | Hold clocks before a qualifying access |
| c2c_same_en_i | input | 1 | Apply hold for same chip-select number |
| c2c_diff_en_i | input | 1 | Apply hold for different chip-select number |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address latch, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| capture_o | output | 1 | Read data capture pulse |
| done_o | output | 1 | Completion pulse |

## Verification
The strobes are decoded from the tick counter in the same clock, so a corrupted tick, direction or state shows at the pins on the very clock it occurs. The symptom is a strobe edge, capture or completion pulse that lands one or more ticks away from its programmed point. A wrong hold or turnaround count moves every later edge of the next access, and the clock-by-clock comparison reports it at that access's first tick. A lost or corrupted pending request shows up as a missing access, or an access with the wrong direction, after the current one finishes.

// File: rtl/csx_pkg.sv
package csx_pkg;

    localparam int NUM_STROBES = 4;
    localparam int SB_CS  = 0;
    localparam int SB_ADV = 1;
    localparam int SB_OE  = 2;
    localparam int SB_WE  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_GAP    = 2'd3
    } csx_state_e;

endpackage

// File: rtl/csx_seq.sv
module csx_seq
    import csx_pkg::*;
#(
    parameter int TICK_W = 5,
    parameter int GAP_W  = 4,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [CS_W-1:0]   req_cs_i,
    input  logic [TICK_W-1:0] rd_len_i,
    input  logic [TICK_W-1:0] wr_len_i,
    input  logic [GAP_W-1:0]  turn_i,
    input  logic [GAP_W-1:0]  c2c_i,
    input  logic              c2c_same_en_i,
    input  logic              c2c_diff_en_i,
    output logic              active_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              write_o,
    output logic              done_o
);

    typedef struct packed {
        csx_state_e        state;
        logic [TICK_W-1:0] tick;
        logic [GAP_W-1:0]  cnt;
        logic              wr;
        logic              pend;
        logic              pend_wr;
        logic [CS_W-1:0]   pend_cs;
        logic              have_prev;
        logic [CS_W-1:0]   last_cs;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              start;
    logic              start_wr;
    logic [CS_W-1:0]   start_cs;
    logic              hold_needed;
    logic [TICK_W-1:0] final_tick;

    always_comb begin
        seq_d      = seq_q;
        start      = 1'b0;
        start_wr   = req_write_i;
        start_cs   = req_cs_i;
        final_tick = seq_q.wr ? wr_len_i : rd_len_i;

        // request intake: pending slot first, then a fresh pulse
        if (seq_q.state == ST_IDLE) begin
            if (seq_q.pend) begin
                start          = 1'b1;
                start_wr       = seq_q.pend_wr;
                start_cs       = seq_q.pend_cs;
                seq_d.pend     = req_i;
                seq_d.pend_wr  = req_write_i;
                seq_d.pend_cs  = req_cs_i;
            end else if (req_i) begin
                start = 1'b1;
            end
        end else if (req_i && !seq_q.pend) begin
            seq_d.pend    = 1'b1;
            seq_d.pend_wr = req_write_i;
            seq_d.pend_cs = req_cs_i;
        end

        hold_needed = seq_q.have_prev && (c2c_i != '0) &&
                      ((start_cs == seq_q.last_cs) ? c2c_same_en_i : c2c_diff_en_i);

        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.wr        = start_wr;
                    seq_d.last_cs   = start_cs;
                    seq_d.have_prev = 1'b1;
                    seq_d.tick      = '0;
                    if (hold_needed) begin
                        seq_d.state = ST_HOLD;
                        seq_d.cnt   = c2c_i;
                    end else begin
                        seq_d.state = ST_ACTIVE;
                    end
                end
            end
            ST_HOLD: begin
                if (seq_q.cnt <= GAP_W'(1)) begin
                    seq_d.state = ST_ACTIVE;
                    seq_d.tick  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (seq_q.tick == final_tick) begin
                    if (turn_i != '0) begin
                        seq_d.state = ST_GAP;
                        seq_d.cnt   = turn_i;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end else begin
                    seq_d.tick = seq_q.tick + 1'b1;
                end
            end
            ST_GAP: begin
                if (seq_q.cnt <= GAP_W'(1)) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o = (seq_q.state == ST_ACTIVE);
    assign tick_o   = seq_q.tick;
    assign write_o  = seq_q.wr;
    assign done_o   = active_o && (seq_q.tick == final_tick);

endmodule

// File: rtl/csx_strobe_win.sv
module csx_strobe_win #(
    parameter int CMP_W = 6
) (
    input  logic             en_i,
    input  logic [CMP_W-1:0] tick_i,
    input  logic [CMP_W-1:0] on_i,
    input  logic [CMP_W-1:0] off_i,
    output logic             act_o
);

    assign act_o = en_i && (tick_i >= on_i) && (tick_i < off_i);

endmodule

// File: rtl/csx_half_retime.sv
module csx_half_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_i,
    input  logic d_i,
    output logic q_o
);

    logic late_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_q <= 1'b0;
        end else begin
            late_q <= d_i;
        end
    end

    assign q_o = dly_i ? late_q : d_i;

endmodule

// File: rtl/csx_cycle_gen.sv
module csx_cycle_gen
    import csx_pkg::*;
#(
    parameter int TICK_W = 5,
    parameter int GAP_W  = 4,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [CS_W-1:0]   req_cs_i,
    input  logic              mux_mode_i,
    input  logic [3:0]        half_dly_i,
    input  logic [TICK_W-1:0] cs_on_i,
    input  logic [TICK_W-1:0] cs_wr_off_i,
    input  logic [TICK_W-1:0] adv_on_i,
    input  logic [TICK_W-1:0] adv_rd_off_i,
    input  logic [TICK_W-1:0] adv_wr_off_i,
    input  logic [TICK_W-1:0] oe_on_i,
    input  logic [TICK_W-1:0] we_on_i,
    input  logic [TICK_W-1:0] we_off_i,
    input  logic [TICK_W-1:0] access_i,
    input  logic [TICK_W-1:0] rd_len_i,
    input  logic [TICK_W-1:0] wr_len_i,
    input  logic [GAP_W-1:0]  turn_i,
    input  logic [GAP_W-1:0]  c2c_i,
    input  logic              c2c_same_en_i,
    input  logic              c2c_diff_en_i,
    output logic              cs_n_o,
    output logic              adv_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic              capture_o,
    output logic              done_o
);

    localparam int CMP_W = TICK_W + 1;

    logic              cyc_active;
    logic [TICK_W-1:0] cyc_tick;
    logic              cyc_wr;

    logic [CMP_W-1:0]       tick_ext;
    logic [CMP_W-1:0]       access_end;
    logic [CMP_W-1:0]       adv_sel_off;
    logic [CMP_W-1:0]       adv_min_off;
    logic [CMP_W-1:0]       on_w  [NUM_STROBES];
    logic [CMP_W-1:0]       off_w [NUM_STROBES];
    logic [NUM_STROBES-1:0] strobe_en;
    logic [NUM_STROBES-1:0] strobe_raw;
    logic [NUM_STROBES-1:0] strobe_out;

    csx_seq #(
        .TICK_W (TICK_W),
        .GAP_W  (GAP_W),
        .CS_W   (CS_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .req_write_i   (req_write_i),
        .req_cs_i      (req_cs_i),
        .rd_len_i      (rd_len_i),
        .wr_len_i      (wr_len_i),
        .turn_i        (turn_i),
        .c2c_i         (c2c_i),
        .c2c_same_en_i (c2c_same_en_i),
        .c2c_diff_en_i (c2c_diff_en_i),
        .active_o      (cyc_active),
        .tick_o        (cyc_tick),
        .write_o       (cyc_wr),
        .done_o        (done_o)
    );

    // window bounds per strobe; read-side off points follow the access tick
    always_comb begin
        tick_ext    = {1'b0, cyc_tick};
        access_end  = {1'b0, access_i} + 1'b1;
        adv_sel_off = cyc_wr ? {1'b0, adv_wr_off_i} : {1'b0, adv_rd_off_i};
        adv_min_off = {1'b0, adv_on_i} + 1'b1;

        on_w[SB_CS]   = {1'b0, cs_on_i};
        off_w[SB_CS]  = cyc_wr ? {1'b0, cs_wr_off_i} : access_end;
        on_w[SB_ADV]  = {1'b0, adv_on_i};
        off_w[SB_ADV] = (mux_mode_i && (adv_sel_off < adv_min_off)) ? adv_min_off : adv_sel_off;
        on_w[SB_OE]   = {1'b0, oe_on_i};
        off_w[SB_OE]  = access_end;
        on_w[SB_WE]   = {1'b0, we_on_i};
        off_w[SB_WE]  = {1'b0, we_off_i};

        strobe_en[SB_CS]  = cyc_active;
        strobe_en[SB_ADV] = cyc_active;
        strobe_en[SB_OE]  = cyc_active && !cyc_wr;
        strobe_en[SB_WE]  = cyc_active && cyc_wr;
    end

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
        csx_strobe_win #(
            .CMP_W (CMP_W)
        ) u_win (
            .en_i   (strobe_en[g]),
            .tick_i (tick_ext),
            .on_i   (on_w[g]),
            .off_i  (off_w[g]),
            .act_o  (strobe_raw[g])
        );

        csx_half_retime u_ret (
            .clk   (clk),
            .rst_n (rst_n),
            .dly_i (half_dly_i[g]),
            .d_i   (strobe_raw[g]),
            .q_o   (strobe_out[g])
        );
    end

    assign cs_n_o    = ~strobe_out[SB_CS];
    assign adv_n_o   = ~strobe_out[SB_ADV];
    assign oe_n_o    = ~strobe_out[SB_OE];
    assign we_n_o    = ~strobe_out[SB_WE];
    assign capture_o = cyc_active && !cyc_wr && (cyc_tick == access_i);

endmodule

// File: rtl/csx_cycle_chk.sv
module csx_cycle_chk #(
    parameter int TICK_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic              wr,
    input logic [TICK_W-1:0] tick,
    input logic              mux_mode,
    input logic [TICK_W-1:0] adv_on,
    input logic              adv_raw,
    input logic              cs_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              capture,
    input logic              done
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> (active && (tick == ($past(tick) + 1'b1)))); // R6

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R2

    AST_CAP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (active && !wr)); // R3

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n)); // R3

    AST_ADV_MUX_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mux_mode && (tick == adv_on)) |-> adv_raw); // R5

    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (cs_n && adv_n && oe_n && we_n && !capture && !done)); // R8

endmodule

bind csx_cycle_gen csx_cycle_chk #(
    .TICK_W (TICK_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cyc_active),
    .wr       (cyc_wr),
    .tick     (cyc_tick),
    .mux_mode (mux_mode_i),
    .adv_on   (adv_on_i),
    .adv_raw  (strobe_raw[1]),
    .cs_n     (cs_n_o),
    .adv_n    (adv_n_o),
    .oe_n     (oe_n_o),
    .we_n     (we_n_o),
    .capture  (capture_o),
    .done     (done_o)
);

// File: tb/csx_cycle_gen_tb.sv
module csx_cycle_gen_tb_top;

    localparam int TICK_W = 5;
    localparam int GAP_W  = 4;
    localparam int CS_W   = 3;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              req_wr = 1'b0;
    logic [CS_W-1:0]   req_cs = '0;
    logic              mux = 1'b0;
    logic [3:0]        half = 4'b0;
    logic [TICK_W-1:0] cs_on = '0, cs_wr_off = '0, adv_on = '0, adv_rd_off = '0;
    logic [TICK_W-1:0] adv_wr_off = '0, oe_on = '0, we_on = '0, we_off = '0;
    logic [TICK_W-1:0] access = '0, rd_len = '0, wr_len = '0;
    logic [GAP_W-1:0]  turn = '0, c2c = '0;
    logic              same_en = 1'b0, diff_en = 1'b0;
    logic cs_n, adv_n, oe_n, we_n, capture, done;

    item_t     sb_q[$];
    int        n_checks = 0;
    int        n_fails  = 0;
    bit        finished = 1'b0;
    logic [3:0] prev_raw = 4'b0;
    bit        have_prev = 1'b0;
    int        last_cs = 0;

    always #5 clk = ~clk;

    csx_cycle_gen #(
        .TICK_W (TICK_W),
        .GAP_W  (GAP_W),
        .CS_W   (CS_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_i (req), .req_write_i (req_wr), .req_cs_i (req_cs),
        .mux_mode_i (mux), .half_dly_i (half),
        .cs_on_i (cs_on), .cs_wr_off_i (cs_wr_off),
        .adv_on_i (adv_on), .adv_rd_off_i (adv_rd_off), .adv_wr_off_i (adv_wr_off),
        .oe_on_i (oe_on), .we_on_i (we_on), .we_off_i (we_off),
        .access_i (access), .rd_len_i (rd_len), .wr_len_i (wr_len),
        .turn_i (turn), .c2c_i (c2c),
        .c2c_same_en_i (same_en), .c2c_diff_en_i (diff_en),
        .cs_n_o (cs_n), .adv_n_o (adv_n), .oe_n_o (oe_n), .we_n_o (we_n),
        .capture_o (capture), .done_o (done)
    );

    // expected vector bits: {cs, adv, oe, we, capture, done}, strobes active high
    task automatic push_vec(input logic [3:0] raw, input logic cap, input logic dn, input string tag);
        logic [3:0] shown;
        item_t it;
        for (int i = 0; i < 4; i++) shown[i] = half[i] ? prev_raw[i] : raw[i];
        prev_raw = raw;
        it.exp = {shown[0], shown[1], shown[2], shown[3], cap, dn};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic push_seq(input bit wr, input int cs, input bit contig,
                            input string tag_act, input string tag_hold);
        int len, cs_off, adv_off, acc_end;
        bit hold;
        logic [3:0] raw;
        if (!contig) prev_raw = 4'b0;
        push_vec(4'b0, 1'b0, 1'b0, tag_act);
        hold = have_prev && (c2c != 0) && ((cs == last_cs) ? same_en : diff_en);
        have_prev = 1'b1;
        last_cs = cs;
        if (hold) for (int k = 0; k < int'(c2c); k++) push_vec(4'b0, 1'b0, 1'b0, tag_hold);
        len = wr ? int'(wr_len) : int'(rd_len);
        acc_end = int'(access) + 1;
        cs_off = wr ? int'(cs_wr_off) : acc_end;
        adv_off = wr ? int'(adv_wr_off) : int'(adv_rd_off);
        if (mux && adv_off < int'(adv_on) + 1) adv_off = int'(adv_on) + 1;
        for (int t = 0; t <= len; t++) begin
            raw[0] = (t >= int'(cs_on)) && (t < cs_off);
            raw[1] = (t >= int'(adv_on)) && (t < adv_off);
            raw[2] = !wr && (t >= int'(oe_on)) && (t < acc_end);
            raw[3] = wr && (t >= int'(we_on)) && (t < int'(we_off));
            push_vec(raw, !wr && (t == int'(access)), t == len, tag_act);
        end
        for (int k = 0; k < int'(turn); k++) push_vec(4'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic start_req(input bit wr, input int cs, input string tag_act, input string tag_hold);
        @(posedge clk); #1;
        req = 1'b1; req_wr = wr; req_cs = CS_W'(cs);
        push_seq(wr, cs, 1'b0, tag_act, tag_hold);
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // monitor: one expected vector per clock while the scoreboard holds items
    initial begin
        forever begin
            @(posedge clk); #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it = sb_q.pop_front();
                act = {~cs_n, ~adv_n, ~oe_n, ~we_n, capture, done};
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s at %0t: actual %b expected %b", it.tag, $time, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #2;
        n_checks++;  // R1 reset state
        if ({cs_n, adv_n, oe_n, we_n, capture, done} !== 6'b111100) begin
            n_fails++;
            $display("FAIL R1: actual %b expected %b", {cs_n, adv_n, oe_n, we_n, capture, done}, 6'b111100);
        end

        cs_on = 5'd1; cs_wr_off = 5'd7; adv_on = 5'd1; adv_rd_off = 5'd3; adv_wr_off = 5'd2;
        oe_on = 5'd3; we_on = 5'd2; we_off = 5'd6; access = 5'd6; rd_len = 5'd8; wr_len = 5'd9;
        turn = 4'd2; c2c = 4'd3;

        // R2 R4 R6 R8 read, first access after reset: no hold (R10)
        start_req(1'b0, 0, "R2", "R10");
        drain();
        // R3 R9 write to same chip select with same-select hold
        same_en = 1'b1;
        start_req(1'b1, 0, "R3", "R9");
        drain();
        // R10 different select, diff hold disabled: no hold
        start_req(1'b0, 1, "R10", "R10");
        drain();
        // R10 different select with diff hold enabled
        diff_en = 1'b1; c2c = 4'd2;
        start_req(1'b0, 2, "R10", "R10");
        drain();
        // R9 same select with same-select hold disabled
        same_en = 1'b0;
        start_req(1'b1, 2, "R6", "R9");
        drain();
        // R5 empty address window, non-multiplexed then multiplexed
        adv_on = 5'd2; adv_rd_off = 5'd2; diff_en = 1'b0;
        start_req(1'b0, 3, "R5", "R5");
        drain();
        mux = 1'b1;
        start_req(1'b0, 3, "R5", "R5");
        drain();
        mux = 1'b0; adv_rd_off = 5'd4;
        // R7 half-clock delay on every strobe, read and write
        half = 4'b1111;
        start_req(1'b0, 4, "R7", "R7");
        drain();
        start_req(1'b1, 4, "R7", "R7");
        drain();
        half = 4'b0101;
        start_req(1'b0, 5, "R7", "R7");
        drain();
        half = 4'b0;
        // R11 request during an access is kept and started after turnaround
        turn = 4'd3; diff_en = 1'b1; c2c = 4'd2;
        start_req(1'b0, 6, "R11", "R10");
        repeat (3) @(posedge clk);
        #1;
        req = 1'b1; req_wr = 1'b1; req_cs = CS_W'(7);
        push_seq(1'b1, 7, 1'b1, "R11", "R11");
        @(posedge clk); #1;
        req = 1'b0;
        drain();
        // R8 zero turnaround back-to-back with pending request
        turn = 4'd0; diff_en = 1'b0;
        start_req(1'b1, 1, "R8", "R8");
        repeat (2) @(posedge clk);
        #1;
        req = 1'b1; req_wr = 1'b0; req_cs = CS_W'(2);
        push_seq(1'b0, 2, 1'b1, "R11", "R11");
        @(posedge clk); #1;
        req = 1'b0;
        drain();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule